// File: doc/BRIEF.md
# External Bus Turnaround Idle Inserter

This block sequences read and write cycles on an external memory bus whose devices sit in numbered address areas. Each cycle has a first state that sets up the address, a second state, and an optional third state for slow devices. A device with a long output float time can keep driving the data lines after its read strobe is released. To stop it clashing with the next device, the sequencer can put one empty bus state in front of the following cycle.

Two hazards are recognised. The first is a read followed directly by a read to a different area. The second is a read followed directly by any write. Each hazard has its own enable bit, held in a small configuration register that comes up with both bits set. A request is taken with a valid/ready handshake. The cycle-done pulse and the next acceptance can fall in the same clock, so cycles run with no gap. Once the bus has sat idle for at least one clock, the history of the last access is forgotten.

Top module: `ebt_turnaround_seq`

## Requirements
- R1: After reset, bus_state is 0 (idle), req_ready is 1, rd_n and wr_n are 1 and done is 0.
- R2: With the read-read enable set, a read accepted in the final state of a read to a different area is preceded by exactly one idle state (bus_state 1). In that state rd_n and wr_n are both 1. The state that follows is T1 (bus_state 2).
- R3: With the read-write enable set, a write accepted in the final state of a read is preceded by one idle state, whatever the two areas are.
- R4: With an enable bit cleared, its hazard gets no idle state, and T1 of the second cycle directly follows the last state of the first.
- R5: Two reads to the same area never get an idle state, and neither does a write followed by a read or a write followed by a write.
- R6: A request accepted from the idle bus state (bus_state 0), whether first after reset or after one or more clocks with no request, goes straight to T1.
- R7: rd_n is 0 from T1 through the last state of a read. wr_n is 0 from T2 (bus_state 3) through the last state of a write. bus_addr holds the request address, stable from T1 through the last state.
- R8: req_long=0 gives T1,T2. req_long=1 gives T1,T2,T3 (bus_state 4). done is high for exactly one clock, in the last state.
- R9: req_ready is 1 in the idle bus state and in the last state of a cycle, and 0 in the inserted idle state and all other access states.
- R10: The enable register resets to both bits set. It loads cfg_rr_en and cfg_rw_en when cfg_we is 1, and its value is used for requests accepted from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the enable register |
| cfg_rr_en | input | 1 | Read-read (different area) idle enable, loaded on cfg_we |
| cfg_rw_en | input | 1 | Read-write idle enable, loaded on cfg_we |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_area | input | AREA_W | Area number of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = three-state cycle |
| req_addr | input | ADDR_W | Request address |
| bus_state | output | 3 | 0 idle, 1 inserted idle, 2 T1, 3 T2, 4 T3 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Address on the bus |
| done | output | 1 | Last state of the current cycle |

## Verification
Every scenario issues a pair of accesses and records the state trace cycle by cycle. The pairs cover: a read to one area then a read to another, the same area twice, a read then a write, a write then a read, and a write then a write, each with short and long lengths. Comparing differing areas with the same area isolates the area compare. Read-then-write pairs in the same area show that the write hazard ignores area. Each enable is cleared on its own, with the other left set, to show that each bit acts only on its own hazard. A pair separated by a single empty clock shows that the history is forgotten.

// File: rtl/ebt_pkg.sv
package ebt_pkg;

   typedef enum logic [2:0] {
      BS_IDLE = 3'd0,
      BS_TI   = 3'd1,
      BS_T1   = 3'd2,
      BS_T2   = 3'd3,
      BS_T3   = 3'd4
   } bus_st_e;

   localparam int BS_W = 3;

endpackage

// File: rtl/ebt_cfg_reg.sv
module ebt_cfg_reg #(
   parameter bit RR_RESET = 1'b1,
   parameter bit RW_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic rr_in,
   input  logic rw_in,
   output logic rr_en,
   output logic rw_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_en <= RR_RESET;
         rw_en <= RW_RESET;
      end else if (we) begin
         rr_en <= rr_in;
         rw_en <= rw_in;
      end
   end

endmodule

// File: rtl/ebt_hazard.sv
module ebt_hazard #(
   parameter int AREA_W   = 3,
   parameter bit RR_GUARD = 1'b1
) (
   input  logic              prev_valid,
   input  logic              prev_write,
   input  logic [AREA_W-1:0] prev_area,
   input  logic              nxt_write,
   input  logic [AREA_W-1:0] nxt_area,
   input  logic              rr_en,
   input  logic              rw_en,
   output logic              insert
);

   logic prev_read;
   logic rw_hit;
   logic rr_hit;

   assign prev_read = prev_valid && !prev_write;
   assign rw_hit    = prev_read && nxt_write && rw_en;

   generate
      if (RR_GUARD) begin : g_rr
         assign rr_hit = prev_read && !nxt_write && rr_en && (prev_area != nxt_area);
      end else begin : g_no_rr
         assign rr_hit = 1'b0;
      end
   endgenerate

   assign insert = rw_hit || rr_hit;

endmodule

// File: rtl/ebt_seq_fsm.sv
module ebt_seq_fsm
   import ebt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int AREA_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              insert,
   input  logic              req_write,
   input  logic              req_long,
   input  logic [AREA_W-1:0] req_area,
   input  logic [ADDR_W-1:0] req_addr,
   output bus_st_e           st,
   output logic              cur_write,
   output logic              cur_long,
   output logic [AREA_W-1:0] cur_area,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              last
);

   bus_st_e st_nxt;
   bus_st_e start_st;

   assign last     = ((st == BS_T2) && !cur_long) || (st == BS_T3);
   assign start_st = insert ? BS_TI : BS_T1;

   always_comb begin
      st_nxt = st;
      unique case (st)
         BS_IDLE: if (accept) st_nxt = start_st;
         BS_TI:   st_nxt = BS_T1;
         BS_T1:   st_nxt = BS_T2;
         BS_T2:   if (cur_long) st_nxt = BS_T3;
                  else st_nxt = accept ? start_st : BS_IDLE;
         BS_T3:   st_nxt = accept ? start_st : BS_IDLE;
         default: st_nxt = BS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= BS_IDLE;
         cur_write <= 1'b0;
         cur_long  <= 1'b0;
         cur_area  <= '0;
         cur_addr  <= '0;
      end else begin
         st <= st_nxt;
         if (accept) begin
            cur_write <= req_write;
            cur_long  <= req_long;
            cur_area  <= req_area;
            cur_addr  <= req_addr;
         end
      end
   end

endmodule

// File: rtl/ebt_strobe_gen.sv
module ebt_strobe_gen
   import ebt_pkg::*;
(
   input  bus_st_e st,
   input  logic    cur_write,
   output logic    rd_n,
   output logic    wr_n
);

   logic in_access;
   logic in_data;

   assign in_access = (st == BS_T1) || (st == BS_T2) || (st == BS_T3);
   assign in_data   = (st == BS_T2) || (st == BS_T3);

   assign rd_n = !(in_access && !cur_write);
   assign wr_n = !(in_data && cur_write);

endmodule

// File: rtl/ebt_turnaround_seq.sv
module ebt_turnaround_seq
   import ebt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int AREA_W   = 3,
   parameter bit RR_GUARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_rr_en,
   input  logic              cfg_rw_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AREA_W-1:0] req_area,
   input  logic              req_write,
   input  logic              req_long,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [BS_W-1:0]   bus_state,
   output logic              rd_n,
   output logic              wr_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              done
);

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ebt_turnaround_seq: ADDR_W out of range");
      end
      if (AREA_W < 1 || AREA_W > 8) begin : g_bad_area_w
         $error("ebt_turnaround_seq: AREA_W out of range");
      end
   endgenerate

   bus_st_e           st;
   logic              cur_write;
   logic              cur_long;
   logic [AREA_W-1:0] cur_area;
   logic              last;
   logic              accept;
   logic              insert;
   logic              rr_en;
   logic              rw_en;

   assign req_ready = (st == BS_IDLE) || last;
   assign accept    = req_valid && req_ready;
   assign done      = last;
   assign bus_state = st;

   ebt_cfg_reg #(
      .RR_RESET (1'b1),
      .RW_RESET (1'b1)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .rr_in (cfg_rr_en),
      .rw_in (cfg_rw_en),
      .rr_en (rr_en),
      .rw_en (rw_en)
   );

   ebt_hazard #(
      .AREA_W   (AREA_W),
      .RR_GUARD (RR_GUARD)
   ) u_haz (
      .prev_valid (last),
      .prev_write (cur_write),
      .prev_area  (cur_area),
      .nxt_write  (req_write),
      .nxt_area   (req_area),
      .rr_en      (rr_en),
      .rw_en      (rw_en),
      .insert     (insert)
   );

   ebt_seq_fsm #(
      .ADDR_W (ADDR_W),
      .AREA_W (AREA_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .insert    (insert),
      .req_write (req_write),
      .req_long  (req_long),
      .req_area  (req_area),
      .req_addr  (req_addr),
      .st        (st),
      .cur_write (cur_write),
      .cur_long  (cur_long),
      .cur_area  (cur_area),
      .cur_addr  (bus_addr),
      .last      (last)
   );

   ebt_strobe_gen u_strb (
      .st        (st),
      .cur_write (cur_write),
      .rd_n      (rd_n),
      .wr_n      (wr_n)
   );

endmodule

// File: rtl/ebt_turnaround_chk.sv
module ebt_turnaround_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        bus_state,
   input logic              rd_n,
   input logic              wr_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              done,
   input logic              req_valid,
   input logic              req_ready
);

   AST_TI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd1) |-> (rd_n && wr_n)); // R2

   AST_TI_THEN_T1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd1) |=> (bus_state == 3'd2)); // R2

   AST_FROM_IDLE_T1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd0 && req_valid && req_ready) |=> (bus_state == 3'd2)); // R6

   AST_NO_WR_IN_T1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd2) |-> wr_n); // R7

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~rd_n, ~wr_n})); // R7

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd3 || bus_state == 3'd4) |-> $stable(bus_addr)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd1 || bus_state == 3'd2) |-> !req_ready); // R9

endmodule

bind ebt_turnaround_seq ebt_turnaround_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_state (bus_state),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .bus_addr  (bus_addr),
   .done      (done),
   .req_valid (req_valid),
   .req_ready (req_ready)
);

// File: tb/ebt_turnaround_seq_bench.sv
`timescale 1ns/1ps
module ebt_turnaround_seq_bench;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we, cfg_rr_en, cfg_rw_en;
   logic          req_valid, req_ready;
   logic [2:0]    req_area;
   logic          req_write, req_long;
   logic [AW-1:0] req_addr;
   logic [2:0]    bus_state;
   logic          rd_n, wr_n, done;
   logic [AW-1:0] bus_addr;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ebt_turnaround_seq #(.ADDR_W(AW), .AREA_W(3)) u_ebt_turnaround_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rr_en(cfg_rr_en),
      .cfg_rw_en(cfg_rw_en), .req_valid(req_valid), .req_ready(req_ready),
      .req_area(req_area), .req_write(req_write), .req_long(req_long),
      .req_addr(req_addr), .bus_state(bus_state), .rd_n(rd_n), .wr_n(wr_n),
      .bus_addr(bus_addr), .done(done)
   );

   // trace recorder, sampled away from the active edge
   logic [2:0]    tr_st   [0:31];
   logic          tr_rd   [0:31];
   logic          tr_wr   [0:31];
   logic          tr_dn   [0:31];
   logic          tr_rdy  [0:31];
   logic [AW-1:0] tr_ad   [0:31];
   int            n_log = 0;
   bit            log_on = 1'b0;

   always @(negedge clk) begin
      if (log_on && n_log < 32) begin
         tr_st[n_log]  = bus_state;
         tr_rd[n_log]  = rd_n;
         tr_wr[n_log]  = wr_n;
         tr_dn[n_log]  = done;
         tr_rdy[n_log] = req_ready;
         tr_ad[n_log]  = bus_addr;
         n_log = n_log + 1;
      end
   end

   task automatic check(input string tag, input bit ok, input string msg);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   task automatic summary_and_end();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic cfg_set(input bit rr, input bit rw);
      @(negedge clk);
      cfg_we = 1'b1; cfg_rr_en = rr; cfg_rw_en = rw;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   // Two accesses; expected trace built from the requirements
   task automatic pair(input string tag,
                       input bit [2:0] a0, input bit w0, input bit l0, input bit [AW-1:0] d0,
                       input bit [2:0] a1, input bit w1, input bit l1, input bit [AW-1:0] d1,
                       input bit exp_ti, input bit gap);
      bit [2:0]    e_st [0:15];
      bit          e_rd [0:15];
      bit          e_wr [0:15];
      bit          e_dn [0:15];
      bit          e_rdy[0:15];
      bit          e_ac [0:15];
      bit [AW-1:0] e_ad [0:15];
      int k = 0;
      for (int p = 0; p < 2; p++) begin
         bit w = p ? w1 : w0;
         bit l = p ? l1 : l0;
         bit [AW-1:0] d = p ? d1 : d0;
         if (p == 1 && gap) begin
            e_st[k]=3'd0; e_rd[k]=1; e_wr[k]=1; e_dn[k]=0; e_rdy[k]=1; e_ac[k]=0; e_ad[k]='0; k++;
         end
         if (p == 1 && exp_ti) begin
            e_st[k]=3'd1; e_rd[k]=1; e_wr[k]=1; e_dn[k]=0; e_rdy[k]=0; e_ac[k]=0; e_ad[k]='0; k++;
         end
         e_st[k]=3'd2; e_rd[k]=w; e_wr[k]=1;  e_dn[k]=0;  e_rdy[k]=0;  e_ac[k]=1; e_ad[k]=d; k++;
         e_st[k]=3'd3; e_rd[k]=w; e_wr[k]=!w; e_dn[k]=!l; e_rdy[k]=!l; e_ac[k]=1; e_ad[k]=d; k++;
         if (l) begin
            e_st[k]=3'd4; e_rd[k]=w; e_wr[k]=!w; e_dn[k]=1; e_rdy[k]=1; e_ac[k]=1; e_ad[k]=d; k++;
         end
      end
      e_st[k]=3'd0; e_rd[k]=1; e_wr[k]=1; e_dn[k]=0; e_rdy[k]=1; e_ac[k]=0; e_ad[k]='0; k++;

      @(negedge clk);
      req_valid = 1'b1; req_area = a0; req_write = w0; req_long = l0; req_addr = d0;
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      n_log = 0; log_on = 1'b1;
      if (gap) begin
         req_valid = 1'b0;
         do @(negedge clk); while (!done);
         @(posedge clk); #1;
      end
      req_valid = 1'b1; req_area = a1; req_write = w1; req_long = l1; req_addr = d1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
      repeat (8) @(negedge clk);
      log_on = 1'b0;

      for (int i = 0; i < k; i++) begin
         bit ok = (tr_st[i] == e_st[i]) && (tr_rd[i] == e_rd[i]) && (tr_wr[i] == e_wr[i]) &&
                  (tr_dn[i] == e_dn[i]) && (tr_rdy[i] == e_rdy[i]) &&
                  (!e_ac[i] || tr_ad[i] == e_ad[i]);
         check({tag, " R7 R8 R9"}, ok,
               $sformatf("cycle %0d act st=%0d rd_n=%0b wr_n=%0b done=%0b rdy=%0b addr=%h exp st=%0d rd_n=%0b wr_n=%0b done=%0b rdy=%0b addr=%h",
                         i, tr_st[i], tr_rd[i], tr_wr[i], tr_dn[i], tr_rdy[i], tr_ad[i],
                         e_st[i], e_rd[i], e_wr[i], e_dn[i], e_rdy[i], e_ad[i]));
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", bus_state == 3'd0 && req_ready && rd_n && wr_n && !done,
            $sformatf("act st=%0d rdy=%0b rd_n=%0b wr_n=%0b done=%0b exp 0 1 1 1 0",
                      bus_state, req_ready, rd_n, wr_n, done));
   endtask

   task automatic t_default_enables();   // R10 reset value, R2
      pair("R10 R2 rd-rd diff area", 3'd0, 0, 0, 16'h1000, 3'd1, 0, 0, 16'h2004, 1, 0);
   endtask

   task automatic t_no_hazard();          // R5, R8
      pair("R5 rd-rd same area",   3'd2, 0, 0, 16'h3000, 3'd2, 0, 1, 16'h3002, 0, 0);
      pair("R5 wr-rd",             3'd1, 1, 1, 16'h4000, 3'd4, 0, 0, 16'h5000, 0, 0);
      pair("R5 R8 wr-wr",          3'd6, 1, 1, 16'h6000, 3'd7, 1, 0, 16'h7000, 0, 0);
   endtask

   task automatic t_read_write();         // R3
      pair("R3 rd-wr same area long", 3'd3, 0, 1, 16'h8000, 3'd3, 1, 1, 16'h8010, 1, 0);
      pair("R3 rd-wr diff area",      3'd5, 0, 0, 16'h9000, 3'd0, 1, 0, 16'h0100, 1, 0);
   endtask

   task automatic t_gap();                // R6
      pair("R6 idle gap clears",      3'd0, 0, 0, 16'hA000, 3'd5, 0, 0, 16'hB000, 0, 1);
   endtask

   task automatic t_enables();            // R4, R10
      cfg_set(1'b0, 1'b0);
      pair("R4 rr off",  3'd0, 0, 0, 16'hC000, 3'd1, 0, 0, 16'hC100, 0, 0);
      pair("R4 rw off",  3'd2, 0, 1, 16'hC200, 3'd2, 1, 0, 16'hC300, 0, 0);
      cfg_set(1'b1, 1'b0);
      pair("R10 rr only, rd-rd", 3'd3, 0, 0, 16'hD000, 3'd4, 0, 0, 16'hD100, 1, 0);
      pair("R10 R4 rr only, rd-wr", 3'd3, 0, 0, 16'hD200, 3'd4, 1, 0, 16'hD300, 0, 0);
      cfg_set(1'b0, 1'b1);
      pair("R10 R4 rw only, rd-rd", 3'd6, 0, 0, 16'hE000, 3'd7, 0, 0, 16'hE100, 0, 0);
      pair("R10 rw only, rd-wr", 3'd6, 0, 1, 16'hE200, 3'd7, 1, 1, 16'hE300, 1, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary_and_end();
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_rr_en = 1'b0; cfg_rw_en = 1'b0;
      req_valid = 1'b0; req_area = '0; req_write = 1'b0; req_long = 1'b0; req_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_default_enables();
      t_no_hazard();
      t_read_write();
      t_gap();
      t_enables();
      repeat (4) @(negedge clk);
      summary_and_end();
   end

endmodule